// File: doc/BRIEF.md
# Privilege-Selected Byte-Order Load/Store Aligner

This block sits between a 64-bit core's load/store pipeline and a byte-addressed memory whose words are held least-significant byte first. For each access it takes the access size, the low address bits, a store or load flag, an unsigned flag and the store data. It then produces the lane-positioned write data and byte strobes for a store, or the extracted and extended result for a load.

The byte order of each access is not fixed. Three big-endian enables exist, one for each privilege level (machine, supervisor, user), and the privilege mode of the access picks the enable that applies. In big-endian order, store data is byte-reversed within the access size before it is placed in its lanes. Load data is taken from its lanes and then byte-reversed before it is extended. All results are registered, so they appear one clock after the request. Accesses are assumed to be naturally aligned; the block does not detect misalignment.

Top module: `lsu_endian_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `rsp_valid`, `wr_strb`, `wr_data` and `ld_data` become zero.
- R2: Privilege encoding: 2'b11 means machine, and `be_machine` selects big-endian. 2'b01 means supervisor, and `be_super` selects. 2'b00 means user, and `be_user` selects. The reserved code 2'b10 always uses little-endian. The enables of the modes not in use have no effect.
- R3: Size encoding: 0 is byte, 1 is halfword, 2 is word and 3 is doubleword. A little-endian store places the low 2^size bytes of `st_data` into lanes starting at lane `req_ofs`, least significant byte lowest. Lanes outside the access are zero.
- R4: A big-endian store reverses the low 2^size bytes of `st_data` before placing them. A doubleword 0xAABBCCDDEEFF1122 therefore gives lane data 0x2211FFEEDDCCBBAA, and a halfword 0xAABB at offset 2 gives 0x00000000BBAA0000.
- R5: For a store, `wr_strb` has exactly 2^size set bits, starting at bit `req_ofs`, in both byte orders. For a load or idle cycle, `wr_strb` is zero. Bytes outside the strobe are therefore kept in memory.
- R6: A little-endian load takes 2^size bytes of `mem_rdata` from lane `req_ofs` upward, with the byte at the lowest lane least significant.
- R7: A big-endian load takes the same bytes with the byte at the lowest lane most significant. For memory word 0x2211FFEEDDCCBBAA at offset 0, it returns 0xAABBCCDDEEFF1122, 0xAABBCCDD, 0xAABB or 0xAA.
- R8: After any reversal, a loaded subword is sign-extended to 64 bits from its most significant bit when `req_unsigned` is 0, and zero-extended when it is 1.
- R9: Results and `rsp_valid` appear one clock after a request. `rsp_valid` is 1 exactly in the cycle after `req_valid` was 1.
- R10: `ld_data` keeps its value in every cycle that follows an idle cycle or a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_store | input | 1 | 1 for store, 0 for load |
| req_size | input | 2 | Access size code |
| req_ofs | input | 3 | Byte offset within the memory word |
| req_unsigned | input | 1 | Zero-extend the load result |
| req_priv | input | 2 | Privilege mode of the access |
| be_machine | input | 1 | Big-endian enable for machine mode |
| be_super | input | 1 | Big-endian enable for supervisor mode |
| be_user | input | 1 | Big-endian enable for user mode |
| st_data | input | 64 | Store data, right-justified |
| mem_rdata | input | 64 | Memory word for a load |
| rsp_valid | output | 1 | Registered results are for a request |
| wr_data | output | 64 | Lane-positioned store data |
| wr_strb | output | 8 | Byte write strobes |
| ld_data | output | 64 | Extended load result |

## Verification
Some behaviours are checked on every cycle. These are the strobe population and starting lane, the zero strobe outside stores, the one-cycle `rsp_valid` relation, the holding of `ld_data`, zero extension of unsigned byte loads, and the pass-through of doublewords whenever the governing enable selects little-endian. The exact byte reversals of subwords in big-endian order, sign extension taken after reversal, and mode independence between the three enables can only be shown by the bench's vectors. The same holds for the preservation of untouched bytes in a strobe-merged memory word.

// File: rtl/lsu_endian_pkg.sv
// Shared widths, encodings and byte-order helpers for the load/store aligner.
// Assumes a data word that is a whole number of bytes and a power of two.
package lsu_endian_pkg;

    localparam int unsigned DATA_W = 64;
    localparam int unsigned LANES  = DATA_W / 8;
    localparam int unsigned OFS_W  = $clog2(LANES);
    localparam int unsigned SIZE_W = $clog2(OFS_W + 1);

    typedef enum logic [1:0] {
        PRIV_USER    = 2'b00,
        PRIV_SUPER   = 2'b01,
        PRIV_RSVD    = 2'b10,
        PRIV_MACHINE = 2'b11
    } priv_e;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [LANES-1:0]  strb_t;

    // Lanes covered by an access of 2^sz bytes starting at lane 0.
    function automatic strb_t size_mask(input logic [SIZE_W-1:0] sz);
        strb_t m;
        for (int i = 0; i < LANES; i++) begin
            m[i] = (i < (1 << sz));
        end
        return m;
    endfunction

    // Mirror the low 2^sz bytes; bytes above the access become zero.
    function automatic word_t reverse_bytes(input word_t d, input logic [SIZE_W-1:0] sz);
        word_t r;
        int    n;
        n = 1 << sz;
        r = '0;
        for (int i = 0; i < LANES; i++) begin
            for (int j = 0; j < LANES; j++) begin
                if ((i < n) && (i + j == n - 1)) begin
                    r[8*i +: 8] = d[8*j +: 8];
                end
            end
        end
        return r;
    endfunction

    // Most significant bit of a 2^sz byte value held right-justified.
    function automatic logic top_bit(input word_t d, input logic [SIZE_W-1:0] sz);
        logic s;
        s = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (i == (1 << sz) - 1) begin
                s = d[8*i + 7];
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/lsu_endian_select.sv
// Chooses the byte order of one access from the privilege mode and the
// three per-mode big-endian enables. The reserved mode code is treated as
// little-endian. Purely combinational.
module lsu_endian_select
    import lsu_endian_pkg::*;
(
    input  logic [1:0] priv,
    input  logic       be_machine,
    input  logic       be_super,
    input  logic       be_user,
    output logic       big_endian
);

    // Pick the enable that governs the current mode.
    always_comb begin
        case (priv_e'(priv))
            PRIV_MACHINE: big_endian = be_machine;
            PRIV_SUPER:   big_endian = be_super;
            PRIV_USER:    big_endian = be_user;
            default:      big_endian = 1'b0;
        endcase
    end

endmodule

// File: rtl/lsu_store_pack.sv
// Store path: trims right-justified store data to the access size,
// byte-reverses it for big-endian order, then shifts it to its lanes.
// Produces the matching strobes. Assumes a naturally aligned offset.
module lsu_store_pack
    import lsu_endian_pkg::*;
(
    input  word_t             data,
    input  logic [SIZE_W-1:0] sz,
    input  logic [OFS_W-1:0]  ofs,
    input  logic              big_endian,
    output word_t             lanes,
    output strb_t             strb
);

    strb_t mask;
    word_t trimmed;
    word_t ordered;

    assign mask = size_mask(sz);

    // Zero every byte above the access size.
    for (genvar g = 0; g < LANES; g++) begin : g_trim
        assign trimmed[8*g +: 8] = mask[g] ? data[8*g +: 8] : 8'h00;
    end

    assign ordered = big_endian ? reverse_bytes(trimmed, sz) : trimmed;
    assign lanes   = ordered << {ofs, 3'b000};
    assign strb    = mask << ofs;

endmodule

// File: rtl/lsu_load_extract.sv
// Load path: shifts the addressed bytes down to lane 0, trims them to the
// access size, byte-reverses them for big-endian order and then extends
// the result by sign or by zero. Assumes a naturally aligned offset.
module lsu_load_extract
    import lsu_endian_pkg::*;
(
    input  word_t             rdata,
    input  logic [SIZE_W-1:0] sz,
    input  logic [OFS_W-1:0]  ofs,
    input  logic              big_endian,
    input  logic              is_unsigned,
    output word_t             result
);

    strb_t mask;
    word_t shifted;
    word_t trimmed;
    word_t ordered;
    logic  fill;

    assign mask    = size_mask(sz);
    assign shifted = rdata >> {ofs, 3'b000};

    // Keep only the bytes inside the access.
    for (genvar g = 0; g < LANES; g++) begin : g_trim
        assign trimmed[8*g +: 8] = mask[g] ? shifted[8*g +: 8] : 8'h00;
    end

    assign ordered = big_endian ? reverse_bytes(trimmed, sz) : trimmed;
    assign fill    = ~is_unsigned & top_bit(ordered, sz);

    // Fill bytes above the access with the extension bit.
    for (genvar g = 0; g < LANES; g++) begin : g_ext
        assign result[8*g +: 8] = mask[g] ? ordered[8*g +: 8] : {8{fill}};
    end

endmodule

// File: rtl/lsu_endian_unit.sv
// Top of the byte-order load/store aligner. Resolves the byte order for
// each access from the privilege mode, runs the store and load paths in
// parallel and registers their results one clock after the request.
// Synchronous active-low reset. Misaligned offsets are not detected.
module lsu_endian_unit
    import lsu_endian_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [OFS_W-1:0]  req_ofs,
    input  logic              req_unsigned,
    input  logic [1:0]        req_priv,
    input  logic              be_machine,
    input  logic              be_super,
    input  logic              be_user,
    input  logic [DATA_W-1:0] st_data,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] wr_data,
    output logic [LANES-1:0]  wr_strb,
    output logic [DATA_W-1:0] ld_data
);

    logic  big_endian;
    word_t st_lanes;
    strb_t st_strb;
    word_t ld_value;

    lsu_endian_select sel_i (
        .priv       (req_priv),
        .be_machine (be_machine),
        .be_super   (be_super),
        .be_user    (be_user),
        .big_endian (big_endian)
    );

    lsu_store_pack pack_i (
        .data       (st_data),
        .sz         (req_size),
        .ofs        (req_ofs),
        .big_endian (big_endian),
        .lanes      (st_lanes),
        .strb       (st_strb)
    );

    lsu_load_extract extract_i (
        .rdata       (mem_rdata),
        .sz          (req_size),
        .ofs         (req_ofs),
        .big_endian  (big_endian),
        .is_unsigned (req_unsigned),
        .result      (ld_value)
    );

    // Register the response flag and the store results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            wr_data   <= '0;
            wr_strb   <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid && req_store) begin
                wr_data <= st_lanes;
                wr_strb <= st_strb;
            end else begin
                wr_strb <= '0;
            end
        end
    end

    // Register the load result only when a load is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_data <= '0;
        end else if (req_valid && !req_store) begin
            ld_data <= ld_value;
        end
    end

endmodule

// File: rtl/lsu_endian_chk.sv
// Cycle-by-cycle properties of the aligner, attached by bind. It observes
// only ports and relates each registered output to the previous cycle's
// request.
module lsu_endian_chk
    import lsu_endian_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_store,
    input logic [SIZE_W-1:0] req_size,
    input logic [OFS_W-1:0]  req_ofs,
    input logic              req_unsigned,
    input logic [1:0]        req_priv,
    input logic              be_machine,
    input logic              be_super,
    input logic              be_user,
    input logic [DATA_W-1:0] st_data,
    input logic [DATA_W-1:0] mem_rdata,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] wr_data,
    input logic [LANES-1:0]  wr_strb,
    input logic [DATA_W-1:0] ld_data
);

    logic little_now;
    assign little_now = (req_priv == 2'b10) ||
                        (req_priv == 2'b11 && !be_machine) ||
                        (req_priv == 2'b01 && !be_super) ||
                        (req_priv == 2'b00 && !be_user);

    assert_rsp_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_rsp_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_strb_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_store) |=> (wr_strb == '0));

    assert_strb_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store) |=> ($countones(wr_strb) == (1 << $past(req_size))));

    assert_strb_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store) |=> wr_strb[$past(req_ofs)]);

    assert_ld_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_store) |=> $stable(ld_data));

    assert_byte_zero_ext_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_store && req_unsigned && req_size == '0)
        |=> (ld_data[DATA_W-1:8] == '0));

    assert_little_dword_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_store && req_size == 2'd3 && little_now)
        |=> (ld_data == $past(mem_rdata)));

    assert_little_dword_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && req_size == 2'd3 && little_now)
        |=> (wr_data == $past(st_data)));

endmodule

bind lsu_endian_unit lsu_endian_chk chk_i (.*);

// File: tb/lsu_endian_unit_tb_top.sv
module lsu_endian_unit_tb_top;
    import lsu_endian_pkg::*;

    localparam logic [63:0] VAL = 64'hAABBCCDDEEFF1122;
    localparam logic [63:0] MEM_LE = 64'hAABBCCDDEEFF1122;
    localparam logic [63:0] MEM_BE = 64'h2211FFEEDDCCBBAA;

    typedef struct packed {
        logic        st;
        logic [1:0]  sz;
        logic [2:0]  ofs;
        logic        uns;
        logic [1:0]  prv;
        logic [2:0]  be;    // {machine, super, user}
        logic [63:0] wd;
        logic [63:0] rd;
        logic [63:0] exp_d;
        logic [7:0]  exp_s;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 2'd3, 3'd0, 1'b0, 2'd3, 3'b000, VAL, 64'd0, VAL, 8'hFF, 4'd3},                    // R3
        '{1'b1, 2'd3, 3'd0, 1'b0, 2'd3, 3'b100, VAL, 64'd0, MEM_BE, 8'hFF, 4'd4},                 // R4
        '{1'b0, 2'd3, 3'd0, 1'b0, 2'd3, 3'b100, 64'd0, MEM_BE, VAL, 8'h00, 4'd7},                 // R7
        '{1'b0, 2'd2, 3'd0, 1'b0, 2'd1, 3'b010, 64'd0, MEM_BE, 64'hFFFFFFFFAABBCCDD, 8'h00, 4'd8},// R8
        '{1'b0, 2'd1, 3'd0, 1'b1, 2'd0, 3'b001, 64'd0, MEM_BE, 64'h000000000000AABB, 8'h00, 4'd7},// R7
        '{1'b0, 2'd0, 3'd0, 1'b0, 2'd0, 3'b001, 64'd0, MEM_BE, 64'hFFFFFFFFFFFFFFAA, 8'h00, 4'd8},// R8
        '{1'b0, 2'd2, 3'd0, 1'b0, 2'd3, 3'b011, 64'd0, MEM_LE, 64'hFFFFFFFFEEFF1122, 8'h00, 4'd2},// R2
        '{1'b0, 2'd1, 3'd0, 1'b1, 2'd3, 3'b011, 64'd0, MEM_LE, 64'h0000000000001122, 8'h00, 4'd6},// R6
        '{1'b0, 2'd0, 3'd0, 1'b0, 2'd1, 3'b101, 64'd0, MEM_LE, 64'h0000000000000022, 8'h00, 4'd2},// R2
        '{1'b1, 2'd1, 3'd2, 1'b0, 2'd1, 3'b010, 64'h123456789ABCAABB, 64'd0, 64'h00000000BBAA0000, 8'h0C, 4'd4}, // R4
        '{1'b1, 2'd2, 3'd4, 1'b0, 2'd0, 3'b110, 64'h11111111DEADBEEF, 64'd0, 64'hDEADBEEF00000000, 8'hF0, 4'd3}, // R3
        '{1'b1, 2'd0, 3'd7, 1'b0, 2'd3, 3'b100, 64'h000000000000005A, 64'd0, 64'h5A00000000000000, 8'h80, 4'd4}, // R4
        '{1'b0, 2'd0, 3'd5, 1'b0, 2'd3, 3'b000, 64'd0, MEM_LE, 64'hFFFFFFFFFFFFFFCC, 8'h00, 4'd6},// R6
        '{1'b0, 2'd1, 3'd6, 1'b0, 2'd1, 3'b010, 64'd0, MEM_BE, 64'h0000000000001122, 8'h00, 4'd7},// R7
        '{1'b0, 2'd2, 3'd4, 1'b1, 2'd3, 3'b100, 64'd0, MEM_BE, 64'h00000000EEFF1122, 8'h00, 4'd8},// R8
        '{1'b0, 2'd3, 3'd0, 1'b0, 2'd2, 3'b111, 64'd0, MEM_BE, MEM_BE, 8'h00, 4'd2}                // R2
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic [1:0]  req_size = '0;
    logic [2:0]  req_ofs = '0;
    logic        req_unsigned = 1'b0;
    logic [1:0]  req_priv = '0;
    logic        be_machine = 1'b0;
    logic        be_super = 1'b0;
    logic        be_user = 1'b0;
    logic [63:0] st_data = '0;
    logic [63:0] mem_rdata = '0;
    logic        rsp_valid;
    logic [63:0] wr_data;
    logic [7:0]  wr_strb;
    logic [63:0] ld_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    lsu_endian_unit dut_i (.*);

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Drive one request at a falling edge; results are sampled one clock later.
    task automatic drive(input vec_t v);
        req_valid    = 1'b1;
        req_store    = v.st;
        req_size     = v.sz;
        req_ofs      = v.ofs;
        req_unsigned = v.uns;
        req_priv     = v.prv;
        {be_machine, be_super, be_user} = v.be;
        st_data      = v.wd;
        mem_rdata    = v.rd;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [63:0] mem_word;
        logic [63:0] held;
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 rsp_valid", {63'd0, rsp_valid}, 64'd0);
        check("R1 wr_strb", {56'd0, wr_strb}, 64'd0);
        check("R1 wr_data", wr_data, 64'd0);
        check("R1 ld_data", ld_data, 64'd0);
        rst_n = 1'b1;

        // Vector table
        for (int k = 0; k < NVEC; k++) begin
            drive(VECS[k]);
            @(negedge clk);
            check($sformatf("R9 rsp_valid vec %0d", k), {63'd0, rsp_valid}, 64'd1);
            if (VECS[k].st) begin
                check($sformatf("R%0d wr_data vec %0d", VECS[k].req, k), wr_data, VECS[k].exp_d);
                check($sformatf("R5 wr_strb vec %0d", k), {56'd0, wr_strb}, {56'd0, VECS[k].exp_s});
            end else begin
                check($sformatf("R%0d ld_data vec %0d", VECS[k].req, k), ld_data, VECS[k].exp_d);
                check($sformatf("R5 no strobe on load vec %0d", k), {56'd0, wr_strb}, 64'd0);
            end
        end

        // R10 and R9: idle cycle keeps the load result and drops rsp_valid
        held = ld_data;
        req_valid = 1'b0;
        mem_rdata = 64'h0123456789ABCDEF;
        @(negedge clk);
        check("R9 rsp_valid idle", {63'd0, rsp_valid}, 64'd0);
        check("R10 ld_data idle", ld_data, held);
        check("R5 wr_strb idle", {56'd0, wr_strb}, 64'd0);

        // R10: a store does not disturb the load result
        drive('{1'b1, 2'd3, 3'd0, 1'b0, 2'd3, 3'b000, 64'h5555AAAA5555AAAA, 64'h0123456789ABCDEF,
                64'd0, 8'h00, 4'd10});
        @(negedge clk);
        check("R10 ld_data after store", ld_data, held);

        // R5/R4: merged halfword store keeps the other bytes of the word
        mem_word = 64'hDEADBEEFDEADBEEF;
        drive('{1'b1, 2'd1, 3'd0, 1'b0, 2'd0, 3'b001, 64'h000000000000AABB, 64'd0,
                64'd0, 8'h00, 4'd5});
        @(negedge clk);
        for (int b = 0; b < 8; b++) begin
            if (wr_strb[b]) mem_word[8*b +: 8] = wr_data[8*b +: 8];
        end
        check("R5 merged halfword", mem_word, 64'hDEADBEEFDEADBBAA);

        // R2: same access, each mode's enable alone, only the governing one matters
        drive('{1'b0, 2'd1, 3'd0, 1'b1, 2'd1, 3'b101, 64'd0, MEM_BE, 64'd0, 8'h00, 4'd2});
        @(negedge clk);
        check("R2 super ignores other enables", ld_data, 64'h000000000000BBAA);
        drive('{1'b0, 2'd1, 3'd0, 1'b1, 2'd0, 3'b110, 64'd0, MEM_BE, 64'd0, 8'h00, 4'd2});
        @(negedge clk);
        check("R2 user ignores other enables", ld_data, 64'h000000000000BBAA);

        // R1: reset mid-run clears nonzero outputs
        drive('{1'b1, 2'd3, 3'd0, 1'b0, 2'd3, 3'b000, VAL, 64'd0, 64'd0, 8'h00, 4'd1});
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run wr_strb", {56'd0, wr_strb}, 64'd0);
        check("R1 mid-run ld_data", ld_data, 64'd0);
        check("R1 mid-run rsp_valid", {63'd0, rsp_valid}, 64'd0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end

endmodule